// File: doc/BRIEF.md
# Dual-Channel CCD Line Assembler

This block sits behind the two digitizers of a linear CCD whose readout is split across two output channels. Channel 1 carries the odd-numbered photosites and channel 2 the even-numbered ones. The timing generator tags every sample with its position inside its own channel. The assembler merges the two streams into one ordered line of active pixels. It estimates the dark offset from the light-shielded pixels at the head of the line and removes that offset from every active pixel, saturating at zero. The dummy positions never reach the output.

Each channel delivers the same sequence. It starts with half of the shielded pixels at positions 0 to N_BLACK/2-1, then half of the dummies, then half of the active pixels. A channel 1 sample may arrive in the same cycle as its channel 2 partner or earlier. It waits in a one-entry holding register until the partner comes. When a channel 2 sample completes a pair, the odd pixel leaves first and the even pixel follows in the next cycle. A sample with no partner raises an error pulse and marks the line bad until the next line begins.

Top module: `ccd_line_asm`

## Requirements
- R1: While reset is applied and after it is released with no input, pix_valid_o, err_o and line_bad_o are 0.
- R2: The black level of a line is the sum of its 32 shielded samples (channel positions 0 to 15 on both channels), shifted right by 5 (floor). It is applied to the active pixels of that same line.
- R3: A pair at channel position p, with 18 <= p <= 5017, yields pixel number 2(p-18)+1 from channel 1 in the cycle after the channel 2 sample is taken, then pixel 2(p-18)+2 from channel 2 in the following cycle.
- R4: pix_data_o equals sample minus black level when the sample is larger than the black level, and 0 otherwise.
- R5: sol_o is 1 exactly with pixel number 1 and eol_o is 1 exactly with pixel number 10000.
- R6: Shielded positions 0 to 15 and dummy positions 16 and 17 produce no output pixel.
- R7: An error pulse appears on err_o in the cycle after either of two events. One is a channel 2 sample with no held or simultaneous channel 1 sample at the same position; that pair is dropped. The other is a channel 1 sample arriving while an unpaired one is still held.
- R8: line_bad_o goes to 1 together with err_o. It stays at 1 until a correct pair at position 0 starts a new line, and it reads 0 in the cycle after that pair.
- R9: A channel 1 sample that arrives earlier than its partner gives the same output as one that arrives in the same cycle.
- R10: Completed pairs are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch1_valid_i | input | 1 | Channel 1 (odd) sample strobe |
| ch1_index_i | input | 13 | Channel 1 position within the line |
| ch1_sample_i | input | 12 | Channel 1 digitized sample |
| ch2_valid_i | input | 1 | Channel 2 (even) sample strobe |
| ch2_index_i | input | 13 | Channel 2 position within the line |
| ch2_sample_i | input | 12 | Channel 2 digitized sample |
| pix_valid_o | output | 1 | Output pixel strobe |
| pix_num_o | output | 14 | Pixel number, 1 to 10000 |
| pix_data_o | output | 12 | Offset-corrected pixel value |
| sol_o | output | 1 | Start of line, with pixel 1 |
| eol_o | output | 1 | End of line, with pixel 10000 |
| err_o | output | 1 | One-cycle pairing error pulse |
| line_bad_o | output | 1 | Current line contains a pairing error |

## Verification
Take the clock edge that samples the channel 2 half of a pair. The odd pixel and any missing-partner error are valid right after that edge. The even pixel and the updated line_bad_o state are valid one edge later. An overrun error is valid right after the edge that samples the offending channel 1 sample. The bench changes inputs on falling edges and reads each result on the falling edge that follows the edge where it is due. For every pair it checks the odd slot and the even slot. Non-active and dropped pairs must leave pix_valid_o low in both slots, so a result that comes a cycle early or late is reported.

// File: rtl/ccd_asm_pkg.sv
package ccd_asm_pkg;

  localparam int unsigned DEF_SAMPLE_W = 12;
  localparam int unsigned DEF_N_BLACK  = 32;
  localparam int unsigned DEF_N_DUMMY  = 4;
  localparam int unsigned DEF_N_ACTIVE = 10000;

  // Where the odd half of a completed pair comes from
  typedef enum logic [1:0] {
    PS_NONE     = 2'd0,
    PS_BUFFERED = 2'd1,
    PS_DIRECT   = 2'd2
  } partner_src_e;

endpackage

// File: rtl/ccd_pair_align.sv
module ccd_pair_align
  import ccd_asm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned IDX_W    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch1_v_i,
  input  logic [IDX_W-1:0]    ch1_idx_i,
  input  logic [SAMPLE_W-1:0] ch1_s_i,
  input  logic                ch2_v_i,
  input  logic [IDX_W-1:0]    ch2_idx_i,
  input  logic [SAMPLE_W-1:0] ch2_s_i,
  output logic                pair_v_o,
  output logic [IDX_W-1:0]    pair_idx_o,
  output logic [SAMPLE_W-1:0] odd_o,
  output logic [SAMPLE_W-1:0] even_o,
  output logic                err_o
);

  logic                buf_v_q, buf_v_n;
  logic [IDX_W-1:0]    buf_idx_q;
  logic [SAMPLE_W-1:0] buf_s_q;
  logic                buf_ld;
  logic                buf_hit, dir_hit, miss, overrun;
  partner_src_e        src;

  always_comb begin
    buf_hit = ch2_v_i & buf_v_q & (buf_idx_q == ch2_idx_i);
    dir_hit = ch2_v_i & ~buf_hit & ch1_v_i & (ch1_idx_i == ch2_idx_i);
    if (buf_hit)      src = PS_BUFFERED;
    else if (dir_hit) src = PS_DIRECT;
    else              src = PS_NONE;

    pair_v_o   = (src != PS_NONE);
    pair_idx_o = ch2_idx_i;
    odd_o      = (src == PS_BUFFERED) ? buf_s_q : ch1_s_i;
    even_o     = ch2_s_i;

    miss    = ch2_v_i & (src == PS_NONE);
    overrun = ch1_v_i & buf_v_q & ~buf_hit;
    err_o   = miss | overrun;

    buf_ld  = ch1_v_i & (src != PS_DIRECT);
    if (buf_ld)       buf_v_n = 1'b1;
    else if (ch2_v_i) buf_v_n = 1'b0;
    else              buf_v_n = buf_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v_q   <= 1'b0;
      buf_idx_q <= '0;
      buf_s_q   <= '0;
    end else begin
      buf_v_q <= buf_v_n;
      if (buf_ld) begin
        buf_idx_q <= ch1_idx_i;
        buf_s_q   <= ch1_s_i;
      end
    end
  end

  // R7: an even sample with nothing to pair against flags an error
  p_orphan_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch2_v_i && !buf_v_q && !ch1_v_i) |-> err_o);

  // R9: an early odd sample is held for its partner
  p_odd_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_v_i && !ch2_v_i && !buf_v_q) |=> (buf_v_q && buf_idx_q == $past(ch1_idx_i)));

endmodule

// File: rtl/ccd_black_est.sv
module ccd_black_est #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned N_BLACK  = 32,
  parameter int unsigned IDX_W    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_v_i,
  input  logic [IDX_W-1:0]    pair_idx_i,
  input  logic [SAMPLE_W-1:0] odd_i,
  input  logic [SAMPLE_W-1:0] even_i,
  output logic [SAMPLE_W-1:0] blk_o
);

  localparam int unsigned SHIFT  = $clog2(N_BLACK);
  localparam int unsigned ACC_W  = SAMPLE_W + SHIFT;
  localparam int unsigned B_PAIR = N_BLACK / 2;

  logic [ACC_W-1:0]    acc_q, acc_n;
  logic [SAMPLE_W-1:0] blk_q, blk_n;
  logic                acc_en, blk_ld;

  always_comb begin
    acc_en = pair_v_i & (pair_idx_i < IDX_W'(B_PAIR));
    acc_n  = ((pair_idx_i == '0) ? '0 : acc_q) + ACC_W'(odd_i) + ACC_W'(even_i);
    blk_ld = acc_en & (pair_idx_i == IDX_W'(B_PAIR - 1));
    blk_n  = SAMPLE_W'(acc_n >> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      blk_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_n;
      if (blk_ld) blk_q <= blk_n;
    end
  end

  assign blk_o = blk_q;

  // R2: pairs past the shielded region leave the black level untouched
  p_black_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_v_i && pair_idx_i >= IDX_W'(B_PAIR)) |=> $stable(blk_o));

endmodule

// File: rtl/ccd_line_emit.sv
module ccd_line_emit #(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned NUM_W     = 14,
  parameter int unsigned FIRST_ACT = 18,
  parameter int unsigned N_ACTIVE  = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_v_i,
  input  logic [IDX_W-1:0]    pair_idx_i,
  input  logic [SAMPLE_W-1:0] odd_i,
  input  logic [SAMPLE_W-1:0] even_i,
  input  logic [SAMPLE_W-1:0] blk_i,
  input  logic                err_i,
  output logic                pix_valid_o,
  output logic [NUM_W-1:0]    pix_num_o,
  output logic [SAMPLE_W-1:0] pix_data_o,
  output logic                sol_o,
  output logic                eol_o,
  output logic                err_o,
  output logic                line_bad_o
);

  localparam int unsigned LAST_ACT = FIRST_ACT + N_ACTIVE / 2 - 1;

  function automatic logic [SAMPLE_W-1:0] sat_sub(input logic [SAMPLE_W-1:0] a,
                                                  input logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[SAMPLE_W] ? '0 : d[SAMPLE_W-1:0];
  endfunction

  logic                out_v_q, out_v_n, sol_q, sol_n, eol_q, eol_n;
  logic [NUM_W-1:0]    out_num_q, out_num_n, hold_num_q;
  logic [SAMPLE_W-1:0] out_dat_q, out_dat_n, hold_dat_q;
  logic                hold_v_q, hold_v_n;
  logic                err_q, bad_q, bad_n;
  logic                is_act, out_en, line_start;
  logic [IDX_W-1:0]    rel;
  logic [NUM_W-1:0]    odd_num;

  always_comb begin
    is_act  = pair_v_i & (pair_idx_i >= IDX_W'(FIRST_ACT)) & (pair_idx_i <= IDX_W'(LAST_ACT));
    rel     = pair_idx_i - IDX_W'(FIRST_ACT);
    odd_num = NUM_W'({rel, 1'b1});
    out_en  = is_act | hold_v_q;

    out_v_n   = 1'b0;
    out_num_n = out_num_q;
    out_dat_n = out_dat_q;
    hold_v_n  = hold_v_q;
    if (is_act) begin
      out_v_n   = 1'b1;
      out_num_n = odd_num;
      out_dat_n = sat_sub(odd_i, blk_i);
      hold_v_n  = 1'b1;
    end else if (hold_v_q) begin
      out_v_n   = 1'b1;
      out_num_n = hold_num_q;
      out_dat_n = hold_dat_q;
      hold_v_n  = 1'b0;
    end
    sol_n = out_v_n & (out_num_n == NUM_W'(1));
    eol_n = out_v_n & (out_num_n == NUM_W'(N_ACTIVE));

    line_start = pair_v_i & (pair_idx_i == '0);
    bad_n      = (line_start ? 1'b0 : bad_q) | err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q    <= 1'b0;
      out_num_q  <= '0;
      out_dat_q  <= '0;
      sol_q      <= 1'b0;
      eol_q      <= 1'b0;
      hold_v_q   <= 1'b0;
      hold_num_q <= '0;
      hold_dat_q <= '0;
      err_q      <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      out_v_q  <= out_v_n;
      sol_q    <= sol_n;
      eol_q    <= eol_n;
      hold_v_q <= hold_v_n;
      err_q    <= err_i;
      bad_q    <= bad_n;
      if (out_en) begin
        out_num_q <= out_num_n;
        out_dat_q <= out_dat_n;
      end
      if (is_act) begin
        hold_num_q <= odd_num + NUM_W'(1);
        hold_dat_q <= sat_sub(even_i, blk_i);
      end
    end
  end

  assign pix_valid_o = out_v_q;
  assign pix_num_o   = out_num_q;
  assign pix_data_o  = out_dat_q;
  assign sol_o       = sol_q;
  assign eol_o       = eol_q;
  assign err_o       = err_q;
  assign line_bad_o  = bad_q;

  // R10: pairs never complete on back-to-back cycles
  p_pair_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_v_i |=> !pair_v_i);

  // R3: an odd pixel is always followed by its even neighbour
  p_even_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && pix_num_o[0]) |=> (pix_valid_o && pix_num_o == $past(pix_num_o) + NUM_W'(1)));

  // R5: line markers sit on the first and last pixel
  p_sol_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sol_o |-> (pix_valid_o && pix_num_o == NUM_W'(1)));
  p_eol_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> (pix_valid_o && pix_num_o == NUM_W'(N_ACTIVE)));

  // R8: an error always leaves the line marked bad
  p_err_marks_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> line_bad_o);

endmodule

// File: rtl/ccd_line_asm.sv
module ccd_line_asm
  import ccd_asm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned N_BLACK  = DEF_N_BLACK,
  parameter int unsigned N_DUMMY  = DEF_N_DUMMY,
  parameter int unsigned N_ACTIVE = DEF_N_ACTIVE,
  localparam int unsigned CH_LEN    = (N_BLACK + N_DUMMY + N_ACTIVE) / 2,
  localparam int unsigned IDX_W     = $clog2(CH_LEN),
  localparam int unsigned NUM_W     = $clog2(N_ACTIVE + 1),
  localparam int unsigned FIRST_ACT = (N_BLACK + N_DUMMY) / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch1_valid_i,
  input  logic [IDX_W-1:0]    ch1_index_i,
  input  logic [SAMPLE_W-1:0] ch1_sample_i,
  input  logic                ch2_valid_i,
  input  logic [IDX_W-1:0]    ch2_index_i,
  input  logic [SAMPLE_W-1:0] ch2_sample_i,
  output logic                pix_valid_o,
  output logic [NUM_W-1:0]    pix_num_o,
  output logic [SAMPLE_W-1:0] pix_data_o,
  output logic                sol_o,
  output logic                eol_o,
  output logic                err_o,
  output logic                line_bad_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                pair_v, pair_err;
  logic [IDX_W-1:0]    pair_idx;
  logic [SAMPLE_W-1:0] pair_odd, pair_even, blk;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ccd_pair_align #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_align (
    .clk(clk), .rst_n(rst_int_n),
    .ch1_v_i(ch1_valid_i), .ch1_idx_i(ch1_index_i), .ch1_s_i(ch1_sample_i),
    .ch2_v_i(ch2_valid_i), .ch2_idx_i(ch2_index_i), .ch2_s_i(ch2_sample_i),
    .pair_v_o(pair_v), .pair_idx_o(pair_idx), .odd_o(pair_odd), .even_o(pair_even),
    .err_o(pair_err)
  );

  ccd_black_est #(.SAMPLE_W(SAMPLE_W), .N_BLACK(N_BLACK), .IDX_W(IDX_W)) u_black (
    .clk(clk), .rst_n(rst_int_n),
    .pair_v_i(pair_v), .pair_idx_i(pair_idx), .odd_i(pair_odd), .even_i(pair_even),
    .blk_o(blk)
  );

  ccd_line_emit #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .NUM_W(NUM_W),
                  .FIRST_ACT(FIRST_ACT), .N_ACTIVE(N_ACTIVE)) u_emit (
    .clk(clk), .rst_n(rst_int_n),
    .pair_v_i(pair_v), .pair_idx_i(pair_idx), .odd_i(pair_odd), .even_i(pair_even),
    .blk_i(blk), .err_i(pair_err),
    .pix_valid_o(pix_valid_o), .pix_num_o(pix_num_o), .pix_data_o(pix_data_o),
    .sol_o(sol_o), .eol_o(eol_o), .err_o(err_o), .line_bad_o(line_bad_o)
  );

  // R6: shielded and dummy pairs never reach the output
  p_no_head_output_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pair_v && pair_idx < IDX_W'(FIRST_ACT) && !pix_valid_o) |=> !pix_valid_o);

endmodule

// File: tb/tb_ccd_line_asm.sv
`timescale 1ns/1ps
module tb_ccd_line_asm;

  localparam int SW        = 12;
  localparam int N_BLACK   = 32;
  localparam int N_DUMMY   = 4;
  localparam int N_ACTIVE  = 10000;
  localparam int CH_LEN    = (N_BLACK + N_DUMMY + N_ACTIVE) / 2;
  localparam int IDX_W     = $clog2(CH_LEN);
  localparam int NUM_W     = $clog2(N_ACTIVE + 1);
  localparam int FIRST_ACT = (N_BLACK + N_DUMMY) / 2;
  localparam int MAXV      = (1 << SW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ch1_v = 1'b0, ch2_v = 1'b0;
  logic [IDX_W-1:0] ch1_idx = '0, ch2_idx = '0;
  logic [SW-1:0]    ch1_s = '0, ch2_s = '0;
  logic             pix_valid, sol, eol, err, line_bad;
  logic [NUM_W-1:0] pix_num;
  logic [SW-1:0]    pix_data;

  int n_checks = 0;
  int n_fail   = 0;
  int o_s[CH_LEN];
  int e_s[CH_LEN];
  int blk_exp;
  bit bad_exp;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ccd_line_asm dut (
    .clk(clk), .rst_n(rst_n),
    .ch1_valid_i(ch1_v), .ch1_index_i(ch1_idx), .ch1_sample_i(ch1_s),
    .ch2_valid_i(ch2_v), .ch2_index_i(ch2_idx), .ch2_sample_i(ch2_s),
    .pix_valid_o(pix_valid), .pix_num_o(pix_num), .pix_data_o(pix_data),
    .sol_o(sol), .eol_o(eol), .err_o(err), .line_bad_o(line_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int corr(input int s);
    return (s > blk_exp) ? s - blk_exp : 0;
  endfunction

  // one output slot: either the given pixel or nothing
  task automatic slot(input bit live, input int num, input int smp);
    if (live) begin
      chk(pix_valid == 1'b1, "R3 valid", int'(pix_valid), 1);
      chk(int'(pix_num) == num, "R3 pixel number", int'(pix_num), num);
      chk(int'(pix_data) == corr(smp), "R4 corrected data", int'(pix_data), corr(smp));
      chk(sol == (num == 1), "R5 start of line", int'(sol), int'(num == 1));
      chk(eol == (num == N_ACTIVE), "R5 end of line", int'(eol), int'(num == N_ACTIVE));
    end else begin
      chk(pix_valid == 1'b0, "R6 no output", int'(pix_valid), 0);
    end
  endtask

  // called on a falling edge; returns on the next pair's falling edge
  task automatic run_pair(input int p, input int lead, input bit drop1,
                          input bit drop2, input bit err_exp);
    bit act, live;
    int num;
    act  = (p >= FIRST_ACT) && (p < FIRST_ACT + N_ACTIVE / 2);
    live = act && !drop1 && !drop2;
    num  = 2 * (p - FIRST_ACT) + 1;
    ch1_v = !drop1; ch1_idx = IDX_W'(p); ch1_s = SW'(o_s[p]);
    if (lead == 0) begin
      ch2_v = !drop2; ch2_idx = IDX_W'(p); ch2_s = SW'(e_s[p]);
    end
    @(negedge clk);
    ch1_v = 1'b0;
    chk(err == err_exp, "R7 error pulse", int'(err), int'(err_exp));
    if (err_exp) bad_exp = 1'b1;
    if (lead != 0) begin
      chk(pix_valid == 1'b0, "R9 nothing before partner", int'(pix_valid), 0);
      ch2_v = !drop2; ch2_idx = IDX_W'(p); ch2_s = SW'(e_s[p]);
      @(negedge clk);
      ch2_v = 1'b0;
    end else begin
      ch2_v = 1'b0;
    end
    slot(live, num, o_s[p]);
    @(negedge clk);
    slot(live, num + 1, e_s[p]);
    chk(line_bad == bad_exp, "R8 line bad state", int'(line_bad), int'(bad_exp));
    if (lead == 0) @(negedge clk);
  endtask

  task automatic run_line(input int mode);
    int sum;
    int q, r;
    q = FIRST_ACT + 100;
    r = FIRST_ACT + 300;
    for (int p = 0; p < CH_LEN; p++) begin
      if (p < N_BLACK / 2) begin
        if (mode == 1)      begin o_s[p] = 200; e_s[p] = 200; end
        else if (mode == 3) begin o_s[p] = 0;   e_s[p] = 0;   end
        else begin o_s[p] = $urandom_range(0, 400); e_s[p] = $urandom_range(0, 400); end
      end else if (p < FIRST_ACT) begin
        o_s[p] = (mode == 3) ? MAXV : $urandom_range(0, MAXV);
        e_s[p] = (mode == 3) ? MAXV : $urandom_range(0, MAXV);
      end else if (mode == 1) begin
        case (p % 6)
          0: begin o_s[p] = 0;   e_s[p] = MAXV; end
          1: begin o_s[p] = 199; e_s[p] = 200;  end
          2: begin o_s[p] = 201; e_s[p] = 0;    end
          default: begin o_s[p] = $urandom_range(0, MAXV); e_s[p] = $urandom_range(0, MAXV); end
        endcase
      end else begin
        o_s[p] = $urandom_range(0, MAXV); e_s[p] = $urandom_range(0, MAXV);
      end
    end
    if (mode == 1) o_s[0] = 231;   // sum 6431 -> floor to 200 (R2)
    sum = 0;
    for (int p = 0; p < N_BLACK / 2; p++) sum += o_s[p] + e_s[p];
    blk_exp = sum >> 5;
    bad_exp = 1'b0;
    for (int p = 0; p < CH_LEN; p++) begin
      if (mode == 2 && p == q)          run_pair(p, 0, 1'b1, 1'b0, 1'b1);  // orphan even (R7)
      else if (mode == 2 && p == r)     run_pair(p, 0, 1'b0, 1'b1, 1'b0);  // even missing
      else if (mode == 2 && p == r + 1) run_pair(p, 0, 1'b0, 1'b0, 1'b1);  // overrun (R7)
      else run_pair(p, int'($urandom_range(0, 1)), 1'b0, 1'b0, 1'b0);
    end
    if (mode == 2) chk(line_bad == 1'b1, "R8 bad held to line end", int'(line_bad), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid in reset", int'(pix_valid), 0);
    chk(line_bad == 1'b0, "R1 line bad in reset", int'(line_bad), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid after reset", int'(pix_valid), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
    chk(line_bad == 1'b0, "R1 line bad after reset", int'(line_bad), 0);
    run_line(0);   // random data, mixed odd lead (R9)
    run_line(1);   // floor and clamp corners (R2, R4)
    run_line(2);   // pairing errors (R7, R8)
    run_line(3);   // zero black level, line bad cleared (R8)
    chk(line_bad == 1'b0, "R8 cleared by clean line", int'(line_bad), 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

endmodule